// File: doc/BRIEF.md
# Tag-Broadcast Reservation Station Scheduler

This block is the scheduling window that sits between a register renamer and one functional unit port. A renamed instruction is written into a free slot. Each slot holds an opcode, the tag of the value it will produce, and two source operands. Each operand is either a value already in hand or the tag of the instruction that still has to produce it. Every cycle a result bus may carry one produced (tag, value) pair. Every pending operand in the window compares its own tag with it and, on a match, takes the value and turns ready.

A slot whose two operands are both ready asks to be dispatched. A select stage grants at most one such slot per cycle, always the one that entered the window first, so instructions leave in the order their data arrive and not in program order. The functional unit port is assumed to accept every grant. A flush input empties the whole window in a single cycle, for use on a pipeline squash.

Top module: `rsSched`

## Requirements
- R1: Out of reset the window is empty: `full` is 0 and `dispValid` is 0.
- R2: An allocation is taken when `allocValid` is 1, `full` is 0 and `flush` is 0. `full` is 1 exactly when all `NUM_ENTRIES` slots hold an instruction. An allocation offered while `full` is 1 is dropped and never dispatched.
- R3: An instruction allocated with both operands marked ready (`allocS1Rdy`/`allocS2Rdy` = 1) is offered on the dispatch port in the cycle after the allocation edge. The port carries its opcode, destination tag and both operand values.
- R4: A pending operand whose tag equals `bcTag` while `bcValid` is 1 captures `bcVal` at that clock edge and becomes ready. The dispatched operand value is the broadcast value.
- R5: A broadcast whose tag differs from a pending operand's tag leaves that operand pending, and the instruction is not dispatched.
- R6: When an allocated operand is pending and its tag matches a broadcast in the same cycle as the allocation, the operand captures the broadcast value at once.
- R7: When several instructions are ready, the one allocated earliest is granted first, whatever slot it occupies.
- R8: At most one instruction is granted per cycle. A granted slot is freed at the next clock edge: it is not granted again, and `full` falls in the cycle after a grant from a full window.
- R9: While `flush` is 1 nothing is dispatched and no allocation is taken. All instructions held in the window are discarded at that edge and are never dispatched afterwards, even if their tags are broadcast later.
- R10: A younger instruction whose operands are ready is dispatched ahead of an older one that is still waiting for a broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard every held instruction |
| allocValid | input | 1 | Allocation request |
| allocOp | input | OP_W | Opcode of the new instruction |
| allocDst | input | TAG_W | Tag of the value the instruction will produce |
| allocS1Rdy | input | 1 | Operand 1 is supplied as a value |
| allocS1Tag | input | TAG_W | Producer tag of operand 1 when pending |
| allocS1Val | input | VAL_W | Operand 1 value when ready |
| allocS2Rdy | input | 1 | Operand 2 is supplied as a value |
| allocS2Tag | input | TAG_W | Producer tag of operand 2 when pending |
| allocS2Val | input | VAL_W | Operand 2 value when ready |
| bcValid | input | 1 | Result bus carries a value this cycle |
| bcTag | input | TAG_W | Tag of the broadcast value |
| bcVal | input | VAL_W | Broadcast value |
| full | output | 1 | No free slot |
| dispValid | output | 1 | A slot is granted this cycle |
| dispOp | output | OP_W | Opcode of the granted slot |
| dispDst | output | TAG_W | Destination tag of the granted slot |
| dispS1Val | output | VAL_W | Operand 1 of the granted slot |
| dispS2Val | output | VAL_W | Operand 2 of the granted slot |

## Verification
The bench builds the block with eight slots, 4-bit tags, 32-bit values and 6-bit opcodes. Eight slots are few enough to fill completely with instructions waiting on one shared tag. That makes the refused ninth allocation, the fall of `full` after the first grant, and a single broadcast waking every slot at once all reachable in a short run. With 4-bit tags the bench can choose broadcast tags that differ from the pending ones. The age ordering is checked by placing a younger instruction in a lower-numbered slot than an older one and waking both together.

// File: rtl/rsSchedPkg.sv
package rsSchedPkg;

  // Strobes the control half hands to the datapath half each cycle.
  typedef struct packed {
    logic allocEn;   // write the incoming instruction into allocIdx
    logic grantEn;   // slot grantIdx leaves the window at this edge
    logic flushEn;   // drop every slot
  } rsStrobe_t;

endpackage

// File: rtl/rsSchedCtrl.sv
module rsSchedCtrl
  import rsSchedPkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   flush,
  input  logic                   allocValid,
  input  logic [NUM_ENTRIES-1:0] entryValid,
  input  logic [NUM_ENTRIES-1:0] entryReady,
  output rsStrobe_t              strb,
  output logic [IDX_W-1:0]       allocIdx,
  output logic [IDX_W-1:0]       grantIdx,
  output logic                   full
);

  // olderQ[i][j] set: slot i was allocated before slot j
  logic [NUM_ENTRIES-1:0] olderQ [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] winVec;
  logic                   anyFree;

  // lowest-numbered free slot
  always_comb begin
    allocIdx = '0;
    anyFree  = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!entryValid[i]) begin
        allocIdx = IDX_W'(i);
        anyFree  = 1'b1;
      end
    end
  end

  assign full = !anyFree;

  // a ready slot wins when no other ready slot is older than it
  always_comb begin
    logic blocked;
    winVec = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      blocked = 1'b0;
      for (int j = 0; j < NUM_ENTRIES; j++) begin
        if (entryReady[j] && olderQ[j][i]) blocked = 1'b1;
      end
      winVec[i] = entryReady[i] & ~blocked;
    end
  end

  always_comb begin
    grantIdx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (winVec[i]) grantIdx = IDX_W'(i);
    end
  end

  always_comb begin
    strb.allocEn = allocValid & anyFree & ~flush;
    strb.grantEn = (|winVec) & ~flush;
    strb.flushEn = flush;
  end

  // new slot is younger than every slot currently held
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) olderQ[i] <= '0;
    end else if (strb.allocEn) begin
      olderQ[allocIdx] <= '0;
      for (int j = 0; j < NUM_ENTRIES; j++) begin
        olderQ[j][allocIdx] <= entryValid[j];
      end
    end
  end

  p_one_grant_r8 : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(winVec));

  p_grant_needs_ready_r8 : assert property (@(posedge clk) disable iff (!rstN)
    (strb.grantEn |-> entryReady[grantIdx]));

endmodule

// File: rtl/rsSchedData.sv
module rsSchedData
  import rsSchedPkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = 3,
  parameter int TAG_W       = 4,
  parameter int VAL_W       = 32,
  parameter int OP_W        = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  rsStrobe_t              strb,
  input  logic [IDX_W-1:0]       allocIdx,
  input  logic [IDX_W-1:0]       grantIdx,
  input  logic [OP_W-1:0]        allocOp,
  input  logic [TAG_W-1:0]       allocDst,
  input  logic                   allocS1Rdy,
  input  logic [TAG_W-1:0]       allocS1Tag,
  input  logic [VAL_W-1:0]       allocS1Val,
  input  logic                   allocS2Rdy,
  input  logic [TAG_W-1:0]       allocS2Tag,
  input  logic [VAL_W-1:0]       allocS2Val,
  input  logic                   bcValid,
  input  logic [TAG_W-1:0]       bcTag,
  input  logic [VAL_W-1:0]       bcVal,
  output logic [NUM_ENTRIES-1:0] entryValid,
  output logic [NUM_ENTRIES-1:0] entryReady,
  output logic [OP_W-1:0]        dispOp,
  output logic [TAG_W-1:0]       dispDst,
  output logic [VAL_W-1:0]       dispS1Val,
  output logic [VAL_W-1:0]       dispS2Val
);

  logic             vld   [NUM_ENTRIES];
  logic             s1Rdy [NUM_ENTRIES];
  logic             s2Rdy [NUM_ENTRIES];
  logic [OP_W-1:0]  opQ   [NUM_ENTRIES];
  logic [TAG_W-1:0] dstQ  [NUM_ENTRIES];
  logic [TAG_W-1:0] s1Tag [NUM_ENTRIES];
  logic [TAG_W-1:0] s2Tag [NUM_ENTRIES];
  logic [VAL_W-1:0] s1Val [NUM_ENTRIES];
  logic [VAL_W-1:0] s2Val [NUM_ENTRIES];

  // operand tags arriving with a new instruction, matched against this cycle's bus
  logic newHit1, newHit2;
  assign newHit1 = bcValid && (bcTag == allocS1Tag);
  assign newHit2 = bcValid && (bcTag == allocS2Tag);

  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : gSlot
    logic loadHere, freeHere, oldHit1, oldHit2;
    assign loadHere = strb.allocEn && (allocIdx == IDX_W'(gi));
    assign freeHere = strb.grantEn && (grantIdx == IDX_W'(gi));
    assign oldHit1  = bcValid && (bcTag == s1Tag[gi]);
    assign oldHit2  = bcValid && (bcTag == s2Tag[gi]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vld[gi]   <= 1'b0;
        s1Rdy[gi] <= 1'b0;
        s2Rdy[gi] <= 1'b0;
        opQ[gi]   <= '0;
        dstQ[gi]  <= '0;
        s1Tag[gi] <= '0;
        s2Tag[gi] <= '0;
        s1Val[gi] <= '0;
        s2Val[gi] <= '0;
      end else if (strb.flushEn) begin
        vld[gi] <= 1'b0;
      end else if (loadHere) begin
        vld[gi]   <= 1'b1;
        opQ[gi]   <= allocOp;
        dstQ[gi]  <= allocDst;
        s1Tag[gi] <= allocS1Tag;
        s2Tag[gi] <= allocS2Tag;
        s1Rdy[gi] <= allocS1Rdy | newHit1;
        s2Rdy[gi] <= allocS2Rdy | newHit2;
        s1Val[gi] <= allocS1Rdy ? allocS1Val : bcVal;
        s2Val[gi] <= allocS2Rdy ? allocS2Val : bcVal;
      end else begin
        if (freeHere) vld[gi] <= 1'b0;
        if (vld[gi] && !s1Rdy[gi] && oldHit1) begin
          s1Rdy[gi] <= 1'b1;
          s1Val[gi] <= bcVal;
        end
        if (vld[gi] && !s2Rdy[gi] && oldHit2) begin
          s2Rdy[gi] <= 1'b1;
          s2Val[gi] <= bcVal;
        end
      end
    end

    assign entryValid[gi] = vld[gi];
    assign entryReady[gi] = vld[gi] & s1Rdy[gi] & s2Rdy[gi];

    p_wake_src1_r4 : assert property (@(posedge clk) disable iff (!rstN)
      (vld[gi] && !s1Rdy[gi] && oldHit1 && !strb.flushEn) |=> s1Rdy[gi]);

    p_wake_src2_r4 : assert property (@(posedge clk) disable iff (!rstN)
      (vld[gi] && !s2Rdy[gi] && oldHit2 && !strb.flushEn) |=> s2Rdy[gi]);
  end

  assign dispOp    = opQ[grantIdx];
  assign dispDst   = dstQ[grantIdx];
  assign dispS1Val = s1Val[grantIdx];
  assign dispS2Val = s2Val[grantIdx];

  p_alloc_into_free_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (strb.allocEn |-> !entryValid[allocIdx]));

  p_free_after_grant_r8 : assert property (@(posedge clk) disable iff (!rstN)
    (strb.grantEn |=> !entryValid[$past(grantIdx)]));

  p_flush_empties_r9 : assert property (@(posedge clk) disable iff (!rstN)
    (strb.flushEn |=> (entryValid == '0)));

endmodule

// File: rtl/rsSched.sv
module rsSched
  import rsSchedPkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int TAG_W       = 4,
  parameter int VAL_W       = 32,
  parameter int OP_W        = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             allocValid,
  input  logic [OP_W-1:0]  allocOp,
  input  logic [TAG_W-1:0] allocDst,
  input  logic             allocS1Rdy,
  input  logic [TAG_W-1:0] allocS1Tag,
  input  logic [VAL_W-1:0] allocS1Val,
  input  logic             allocS2Rdy,
  input  logic [TAG_W-1:0] allocS2Tag,
  input  logic [VAL_W-1:0] allocS2Val,
  input  logic             bcValid,
  input  logic [TAG_W-1:0] bcTag,
  input  logic [VAL_W-1:0] bcVal,
  output logic             full,
  output logic             dispValid,
  output logic [OP_W-1:0]  dispOp,
  output logic [TAG_W-1:0] dispDst,
  output logic [VAL_W-1:0] dispS1Val,
  output logic [VAL_W-1:0] dispS2Val
);

  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  rsStrobe_t              strb;
  logic [IDX_W-1:0]       allocIdx, grantIdx;
  logic [NUM_ENTRIES-1:0] entryValid, entryReady;

  rsSchedCtrl #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .flush(flush), .allocValid(allocValid),
    .entryValid(entryValid), .entryReady(entryReady), .strb(strb),
    .allocIdx(allocIdx), .grantIdx(grantIdx), .full(full)
  );

  rsSchedData #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W),
                .VAL_W(VAL_W), .OP_W(OP_W)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .allocIdx(allocIdx), .grantIdx(grantIdx),
    .allocOp(allocOp), .allocDst(allocDst),
    .allocS1Rdy(allocS1Rdy), .allocS1Tag(allocS1Tag), .allocS1Val(allocS1Val),
    .allocS2Rdy(allocS2Rdy), .allocS2Tag(allocS2Tag), .allocS2Val(allocS2Val),
    .bcValid(bcValid), .bcTag(bcTag), .bcVal(bcVal),
    .entryValid(entryValid), .entryReady(entryReady),
    .dispOp(dispOp), .dispDst(dispDst), .dispS1Val(dispS1Val), .dispS2Val(dispS2Val)
  );

  assign dispValid = strb.grantEn;

endmodule

// File: tb/rsSched_tb_top.sv
module rsSched_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush, allocValid, allocS1Rdy, allocS2Rdy, bcValid;
  logic [5:0]  allocOp;
  logic [3:0]  allocDst, allocS1Tag, allocS2Tag, bcTag;
  logic [31:0] allocS1Val, allocS2Val, bcVal;
  logic        full, dispValid;
  logic [5:0]  dispOp;
  logic [3:0]  dispDst;
  logic [31:0] dispS1Val, dispS2Val;

  int checkCnt = 0;
  int failCnt  = 0;

  always #4 clk = ~clk;   // 8 ns period

  rsSched #(.NUM_ENTRIES(8), .TAG_W(4), .VAL_W(32), .OP_W(6)) dut_i (
    .clk(clk), .rstN(rstN), .flush(flush), .allocValid(allocValid),
    .allocOp(allocOp), .allocDst(allocDst),
    .allocS1Rdy(allocS1Rdy), .allocS1Tag(allocS1Tag), .allocS1Val(allocS1Val),
    .allocS2Rdy(allocS2Rdy), .allocS2Tag(allocS2Tag), .allocS2Val(allocS2Val),
    .bcValid(bcValid), .bcTag(bcTag), .bcVal(bcVal),
    .full(full), .dispValid(dispValid), .dispOp(dispOp), .dispDst(dispDst),
    .dispS1Val(dispS1Val), .dispS2Val(dispS2Val)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    flush = 0; allocValid = 0; allocOp = '0; allocDst = '0;
    allocS1Rdy = 0; allocS1Tag = '0; allocS1Val = '0;
    allocS2Rdy = 0; allocS2Tag = '0; allocS2Val = '0;
    bcValid = 0; bcTag = '0; bcVal = '0;
  endtask

  task automatic putAlloc(input logic [5:0] op, input logic [3:0] dst,
                          input logic r1, input logic [3:0] t1, input logic [31:0] v1,
                          input logic r2, input logic [3:0] t2, input logic [31:0] v2);
    allocValid = 1; allocOp = op; allocDst = dst;
    allocS1Rdy = r1; allocS1Tag = t1; allocS1Val = v1;
    allocS2Rdy = r2; allocS2Tag = t2; allocS2Val = v2;
  endtask

  task automatic putBc(input logic [3:0] t, input logic [31:0] v);
    bcValid = 1; bcTag = t; bcVal = v;
  endtask

  // advance past the next rising edge, then return inputs to idle
  task automatic step();
    @(posedge clk); #1; idle();
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic tReset();
    settle();
    chk("R1 full after reset", full, 0);
    chk("R1 dispValid after reset", dispValid, 0);
  endtask

  task automatic tReadyAlloc();
    putAlloc(6'd3, 4'd5, 1, 4'd0, 32'h11, 1, 4'd0, 32'h22);
    step(); settle();
    chk("R3 dispValid", dispValid, 1);
    chk("R3 dispDst", dispDst, 5);
    chk("R3 dispOp", dispOp, 3);
    chk("R3 dispS1Val", dispS1Val, 32'h11);
    chk("R3 dispS2Val", dispS2Val, 32'h22);
    step(); settle();
    chk("R8 no second grant", dispValid, 0);
  endtask

  task automatic tWakeup();
    putAlloc(6'd1, 4'd1, 0, 4'd3, 32'h0, 1, 4'd0, 32'hAA);
    step(); settle();
    chk("R4 waits for tag", dispValid, 0);
    putAlloc(6'd2, 4'd2, 1, 4'd0, 32'h5, 1, 4'd0, 32'h6);
    putBc(4'd4, 32'hDEAD);
    step(); settle();
    chk("R10 younger ready goes first", dispValid, 1);
    chk("R10 younger dst", dispDst, 2);
    step(); settle();
    chk("R5 mismatched tag no wake", dispValid, 0);
    putBc(4'd3, 32'h12345678);
    step(); settle();
    chk("R4 woken dispValid", dispValid, 1);
    chk("R4 woken dst", dispDst, 1);
    chk("R4 captured value", dispS1Val, 32'h12345678);
    chk("R4 other operand", dispS2Val, 32'hAA);
    step(); settle();
    chk("R8 empty after wake test", dispValid, 0);
  endtask

  task automatic tSameCycle();
    putAlloc(6'd7, 4'd3, 0, 4'd7, 32'h0, 0, 4'd7, 32'h0);
    putBc(4'd7, 32'hCAFE);
    step(); settle();
    chk("R6 same-cycle capture dispValid", dispValid, 1);
    chk("R6 operand 1", dispS1Val, 32'hCAFE);
    chk("R6 operand 2", dispS2Val, 32'hCAFE);
    step();
  endtask

  task automatic tAge();
    putAlloc(6'd4, 4'd4, 1, 4'd0, 32'h1, 1, 4'd0, 32'h2);  // slot 0, leaves next cycle
    step(); settle();
    chk("R3 filler dispatched", dispDst, 4);
    putAlloc(6'd8, 4'd1, 0, 4'd9, 32'h0, 1, 4'd0, 32'h3);  // older, slot 1
    step();
    putAlloc(6'd9, 4'd2, 0, 4'd9, 32'h0, 1, 4'd0, 32'h4);  // younger, slot 0
    step();
    putBc(4'd9, 32'h99);
    step(); settle();
    chk("R7 oldest first valid", dispValid, 1);
    chk("R7 oldest first dst", dispDst, 1);
    step(); settle();
    chk("R7 younger second dst", dispDst, 2);
    chk("R7 younger second valid", dispValid, 1);
    step(); settle();
    chk("R8 drained", dispValid, 0);
  endtask

  task automatic tFull();
    for (int k = 0; k < 8; k++) begin
      putAlloc(6'(k), 4'(k), 0, 4'd15, 32'h0, 1, 4'd0, 32'(k));
      step();
    end
    settle();
    chk("R2 full with eight held", full, 1);
    putAlloc(6'd20, 4'd9, 1, 4'd0, 32'h7, 1, 4'd0, 32'h8);
    step(); settle();
    chk("R2 refused alloc not dispatched", dispValid, 0);
    chk("R2 still full", full, 1);
    putBc(4'd15, 32'hF0F0);
    step();
    for (int k = 0; k < 8; k++) begin
      settle();
      chk("R8 one grant per cycle", dispValid, 1);
      chk("R7 age order in full window", dispDst, 4'(k));
      if (k == 1) chk("R8 full falls after first grant", full, 0);
      step();
    end
    settle();
    chk("R2 refused alloc never appears", dispValid, 0);
  endtask

  task automatic tFlush();
    putAlloc(6'd1, 4'd1, 0, 4'd11, 32'h0, 1, 4'd0, 32'h1);
    step();
    putAlloc(6'd2, 4'd2, 0, 4'd11, 32'h0, 1, 4'd0, 32'h2);
    step();
    putAlloc(6'd3, 4'd3, 1, 4'd0, 32'h3, 1, 4'd0, 32'h3);
    step();
    flush = 1;
    putAlloc(6'd4, 4'd4, 1, 4'd0, 32'h4, 1, 4'd0, 32'h4);
    settle();
    chk("R9 no dispatch during flush", dispValid, 0);
    step(); settle();
    chk("R9 window empty after flush", full, 0);
    chk("R9 alloc during flush dropped", dispValid, 0);
    putBc(4'd11, 32'hBB);
    step(); settle();
    chk("R9 flushed slots stay gone", dispValid, 0);
    step(); settle();
    chk("R9 still nothing", dispValid, 0);
    putAlloc(6'd6, 4'd6, 1, 4'd0, 32'h6, 1, 4'd0, 32'h6);
    step(); settle();
    chk("R9 works after flush", dispDst, 6);
    step();
  endtask

  initial begin
    #(8 * 20000);
    checkCnt++; failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tReset();
    tReadyAlloc();
    tWakeup();
    tSameCycle();
    tAge();
    tFull();
    tFlush();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule